// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block produces the background memory reads of a tile-based video generator. On each visible scanline and on the pre-render scanline it divides the active dots into groups of eight. Each group makes four reads: the tile index from the name area, the colour attribute byte, then the low and the high pattern bit-plane of that tile. Every address comes from the packed scroll-address register (`vaddr`): fine Y in bits 14:12, name-area select in bits 11:10, coarse Y in bits 9:5 and coarse X in bits 4:0. The pattern-table half is chosen by `bg_hi_table`.

Each read takes two dots. On the first dot the block drives `rd_addr` and raises `rd_strobe`. The memory registers that address at the clock edge and returns the byte on `rd_data` during the second dot. The block captures the byte at the end of that second dot. When the high plane has been captured, the four bytes are handed to the pixel shifter through a valid/ready output. On the same dot `coarse_x_inc` asks the scroll-address owner to step coarse X.

The tile output keeps to these back-pressure rules. While `tile_valid` is high and `tile_ready` is low, the tile bytes stay frozen. A tile is taken on any edge where both are high. The fetch cadence is set by the dot counter and never stalls. A tile that completes while the output still holds a tile that is not taken on that edge is discarded. Its coarse X request is still issued.

Top module: `bg_fetch_seq`

## Requirements
- R1: During and straight after reset `tile_valid` is 0 and no read strobe is issued while rendering is disabled.
- R2: With phase = (dot-1) mod 8, `rd_strobe` is high on phases 0, 2, 4 and 6 and low on odd phases. The reads are, in order, tile index (phase 0), attribute (phase 2), pattern low plane (phase 4) and pattern high plane (phase 6).
- R3: The tile-index address is 0x2000 OR `vaddr[11:0]`.
- R4: The attribute address is 0x23C0 OR (`vaddr` AND 0x0C00) OR (`vaddr[9:7]` << 3) OR `vaddr[4:2]`.
- R5: The pattern address is (`bg_hi_table` << 12) OR (tile index byte << 4) OR (plane << 3) OR `vaddr[14:12]`. The plane is 0 for the low read and 1 for the high read.
- R6: Fetching happens only on dots 1 to 256 and 321 to 336, and only on lines below 240 or on line 261. Dot 0, dots 257 to 320 and dots above 336 issue no strobe.
- R7: With `render_en` low, no strobe, no `coarse_x_inc` and no new tile are produced.
- R8: One clock after the phase-7 dot, `tile_valid` is high and the tile outputs hold the four captured bytes. The tile index byte is the one returned for the phase-0 read, the attribute byte the one for phase 2, and so on.
- R9: `coarse_x_inc` is high for exactly the phase-7 dot of each active group.
- R10: While `tile_valid` is high and `tile_ready` is low, the tile outputs are stable. A tile completed during that time is dropped. `tile_valid` clears on the edge where `tile_ready` is high and no new tile completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot | input | 9 | Current dot within the line |
| line | input | 9 | Current scanline |
| render_en | input | 1 | Background rendering enable |
| vaddr | input | 15 | Packed scroll-address register |
| bg_hi_table | input | 1 | Selects the pattern half at 0x1000 |
| rd_addr | output | 14 | Read address, valid while rd_strobe is high |
| rd_strobe | output | 1 | Read request for this dot |
| rd_data | input | 8 | Byte returned one clock after the strobe |
| coarse_x_inc | output | 1 | Request to step coarse X |
| tile_valid | output | 1 | A completed tile is held |
| tile_ready | input | 1 | The shifter takes the tile |
| tile_name | output | 8 | Tile index byte |
| tile_attr | output | 8 | Attribute byte |
| tile_plo | output | 8 | Pattern low plane |
| tile_phi | output | 8 | Pattern high plane |

## Verification
`rd_strobe`, `rd_addr` and `coarse_x_inc` are combinational from the dot, line and `vaddr` of the same cycle. The bench drives each dot after the falling edge and samples these outputs one time step later, within the same dot. The byte read is due on `rd_data` during the next dot. The tile is due one rising edge after the phase-7 dot, so the bench reads it after the falling edge that follows. Back-pressure is checked by holding `tile_ready` low across a whole second group and comparing the held bytes to the first tile.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SLOT_NAME = 2'd0,
    SLOT_ATTR = 2'd1,
    SLOT_PLO  = 2'd2,
    SLOT_PHI  = 2'd3
  } slot_e;

  typedef struct packed {
    logic [BYTE_W-1:0] name;
    logic [BYTE_W-1:0] attr;
    logic [BYTE_W-1:0] plo;
    logic [BYTE_W-1:0] phi;
  } tile_t;
endpackage

// File: rtl/bgf_phase_ctrl.sv
module bgf_phase_ctrl #(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261,
  parameter int RUN_LAST  = 256,
  parameter int PRE_FIRST = 321,
  parameter int PRE_LAST  = 336
) (
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              render_en,
  output logic              fetch_on,
  output bgf_pkg::slot_e    slot,
  output logic              issue,
  output logic              capture
);
  localparam logic [DOT_W-1:0]  DOT_ONE   = DOT_W'(1);
  localparam logic [DOT_W-1:0]  DOT_RUN_L = DOT_W'(RUN_LAST);
  localparam logic [DOT_W-1:0]  DOT_PRE_F = DOT_W'(PRE_FIRST);
  localparam logic [DOT_W-1:0]  DOT_PRE_L = DOT_W'(PRE_LAST);
  localparam logic [LINE_W-1:0] LN_VIS    = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] LN_PRE    = LINE_W'(PRE_LINE);

  logic [DOT_W-1:0] dot_m1;
  logic [2:0]       phase;
  logic             line_ok;
  logic             dot_ok;

  always_comb begin
    dot_m1   = dot - DOT_ONE;
    phase    = dot_m1[2:0];
    line_ok  = (line < LN_VIS) || (line == LN_PRE);
    dot_ok   = ((dot >= DOT_ONE) && (dot <= DOT_RUN_L)) ||
               ((dot >= DOT_PRE_F) && (dot <= DOT_PRE_L));
    fetch_on = render_en && line_ok && dot_ok;
    slot     = bgf_pkg::slot_e'(phase[2:1]);
    issue    = fetch_on && !phase[0];
    capture  = fetch_on && phase[0];
  end
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen #(
  parameter int ADDR_W  = 14,
  parameter int VADDR_W = 15
) (
  input  bgf_pkg::slot_e                  slot,
  input  logic                            issue,
  input  logic [VADDR_W-1:0]              vaddr,
  input  logic [bgf_pkg::BYTE_W-1:0]      name_byte,
  input  logic                            hi_table,
  output logic [ADDR_W-1:0]               addr
);
  logic [ADDR_W-1:0] a_name, a_attr, a_plo, a_phi;

  always_comb begin
    a_name = {2'b10, vaddr[11:0]};
    a_attr = {2'b10, vaddr[11:10], 4'b1111, vaddr[9:7], vaddr[4:2]};
    a_plo  = {1'b0, hi_table, name_byte, 1'b0, vaddr[14:12]};
    a_phi  = {1'b0, hi_table, name_byte, 1'b1, vaddr[14:12]};
    addr   = '0;
    if (issue) begin
      unique case (slot)
        bgf_pkg::SLOT_NAME: addr = a_name;
        bgf_pkg::SLOT_ATTR: addr = a_attr;
        bgf_pkg::SLOT_PLO:  addr = a_plo;
        default:            addr = a_phi;
      endcase
    end
  end
endmodule

// File: rtl/bgf_tile_latch.sv
module bgf_tile_latch (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  bgf_pkg::slot_e             slot,
  input  logic [bgf_pkg::BYTE_W-1:0] rd_data,
  output logic [bgf_pkg::BYTE_W-1:0] name_q,
  output logic                       done,
  output bgf_pkg::tile_t             tile
);
  logic [bgf_pkg::BYTE_W-1:0] attr_q, plo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      name_q <= '0;
      attr_q <= '0;
      plo_q  <= '0;
    end else if (capture) begin
      case (slot)
        bgf_pkg::SLOT_NAME: name_q <= rd_data;
        bgf_pkg::SLOT_ATTR: attr_q <= rd_data;
        bgf_pkg::SLOT_PLO:  plo_q  <= rd_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    done      = capture && (slot == bgf_pkg::SLOT_PHI);
    tile.name = name_q;
    tile.attr = attr_q;
    tile.plo  = plo_q;
    tile.phi  = rd_data;
  end
endmodule

// File: rtl/bgf_tile_out.sv
module bgf_tile_out (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done,
  input  bgf_pkg::tile_t tile_in,
  input  logic           ready,
  output logic           valid,
  output bgf_pkg::tile_t tile_q
);
  logic slot_free;

  always_comb slot_free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      tile_q <= '0;
    end else if (done && slot_free) begin
      valid  <= 1'b1;
      tile_q <= tile_in;
    end else if (ready) begin
      valid  <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(tile_q)); // R10
  AST_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && slot_free |=> valid); // R8
endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq #(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int ADDR_W    = 14,
  parameter int VADDR_W   = 15,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261,
  parameter int RUN_LAST  = 256,
  parameter int PRE_FIRST = 321,
  parameter int PRE_LAST  = 336
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DOT_W-1:0]   dot,
  input  logic [LINE_W-1:0]  line,
  input  logic               render_en,
  input  logic [VADDR_W-1:0] vaddr,
  input  logic               bg_hi_table,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_strobe,
  input  logic [7:0]         rd_data,
  output logic               coarse_x_inc,
  output logic               tile_valid,
  input  logic               tile_ready,
  output logic [7:0]         tile_name,
  output logic [7:0]         tile_attr,
  output logic [7:0]         tile_plo,
  output logic [7:0]         tile_phi
);
  logic           fetch_on, issue, capture, done;
  bgf_pkg::slot_e slot;
  logic [7:0]     name_q;
  bgf_pkg::tile_t tile_new, tile_held;

  bgf_phase_ctrl #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE),
    .RUN_LAST(RUN_LAST), .PRE_FIRST(PRE_FIRST), .PRE_LAST(PRE_LAST)
  ) u_phase (
    .dot(dot), .line(line), .render_en(render_en),
    .fetch_on(fetch_on), .slot(slot), .issue(issue), .capture(capture)
  );

  bgf_addr_gen #(.ADDR_W(ADDR_W), .VADDR_W(VADDR_W)) u_addr (
    .slot(slot), .issue(issue), .vaddr(vaddr), .name_byte(name_q),
    .hi_table(bg_hi_table), .addr(rd_addr)
  );

  bgf_tile_latch u_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture), .slot(slot),
    .rd_data(rd_data), .name_q(name_q), .done(done), .tile(tile_new)
  );

  bgf_tile_out u_out (
    .clk(clk), .rst_n(rst_n), .done(done), .tile_in(tile_new),
    .ready(tile_ready), .valid(tile_valid), .tile_q(tile_held)
  );

  always_comb begin
    rd_strobe    = issue;
    coarse_x_inc = done;
    tile_name    = tile_held.name;
    tile_attr    = tile_held.attr;
    tile_plo     = tile_held.plo;
    tile_phi     = tile_held.phi;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |-> !rd_strobe && !coarse_x_inc); // R7
  AST_NAME_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && slot == bgf_pkg::SLOT_NAME |-> rd_addr[13:12] == 2'b10); // R3
  AST_ATTR_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && slot == bgf_pkg::SLOT_ATTR |-> rd_addr[9:6] == 4'hF); // R4
  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> fetch_on && dot != '0); // R6
endmodule

// File: tb/bg_fetch_seq_test.sv
module bg_fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  dot = '0;
  logic [8:0]  line = '0;
  logic        render_en = 1'b0;
  logic [14:0] vaddr = '0;
  logic        bg_hi_table = 1'b0;
  logic [13:0] rd_addr;
  logic        rd_strobe;
  logic [7:0]  rd_data = '0;
  logic        coarse_x_inc;
  logic        tile_valid;
  logic        tile_ready = 1'b1;
  logic [7:0]  tile_name, tile_attr, tile_plo, tile_phi;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bg_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .render_en(render_en),
    .vaddr(vaddr), .bg_hi_table(bg_hi_table), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .coarse_x_inc(coarse_x_inc),
    .tile_valid(tile_valid), .tile_ready(tile_ready), .tile_name(tile_name),
    .tile_attr(tile_attr), .tile_plo(tile_plo), .tile_phi(tile_phi)
  );

  function automatic logic [7:0] memf(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], a[1:0]};
  endfunction

  always_ff @(posedge clk) if (rd_strobe) rd_data <= memf(rd_addr);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [14:0] V_VA[NV] = '{15'h0000, 15'h7FFF, 15'h2345, 15'h5C87, 15'h2345, 15'h5C87};
  localparam logic        V_HI[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [8:0]  V_LN[NV] = '{9'd0, 9'd100, 9'd239, 9'd261, 9'd5, 9'd50};
  localparam logic [8:0]  V_SD[NV] = '{9'd1, 9'd9, 9'd249, 9'd321, 9'd329, 9'd17};
  localparam logic [13:0] V_NT[NV] = '{14'h2000, 14'h2FFF, 14'h2345, 14'h2C87, 14'h2345, 14'h2C87};
  localparam logic [13:0] V_AT[NV] = '{14'h23C0, 14'h2FFF, 14'h23F1, 14'h2FC9, 14'h23F1, 14'h2FC9};

  // Runs one 8-dot group; checks strobes, addresses (R2-R5) and the X step (R9).
  task automatic run_group(input logic [8:0] sd, input logic [14:0] va, input logic hi,
                           input logic [8:0] ln, input logic [13:0] ant,
                           input logic [13:0] aat, input bit active);
    logic [7:0]  nb;
    logic [13:0] exp_a;
    nb = memf(ant);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      dot = sd + 9'(k); line = ln; vaddr = va; bg_hi_table = hi;
      #1;
      check(rd_strobe == (active && (k % 2 == 0)), "R2/R6 strobe", rd_strobe,
            int'(active && (k % 2 == 0)));
      if (active && (k % 2 == 0)) begin
        case (k)
          0: exp_a = ant;
          2: exp_a = aat;
          4: exp_a = {1'b0, hi, nb, 1'b0, va[14:12]};
          default: exp_a = {1'b0, hi, nb, 1'b1, va[14:12]};
        endcase
        check(rd_addr == exp_a, (k == 0) ? "R3 name addr" : (k == 2) ? "R4 attr addr" :
              "R5 pattern addr", rd_addr, exp_a);
      end
      check(coarse_x_inc == (active && k == 7), "R9 coarse_x_inc", coarse_x_inc,
            int'(active && k == 7));
    end
  endtask

  task automatic check_tile(input logic [13:0] ant, input logic [13:0] aat,
                            input logic hi, input logic [14:0] va);
    logic [7:0] nb;
    nb = memf(ant);
    check(tile_valid == 1'b1, "R8 tile_valid", tile_valid, 1);
    check(tile_name == nb, "R8 tile name", tile_name, nb);
    check(tile_attr == memf(aat), "R8 tile attr", tile_attr, memf(aat));
    check(tile_plo == memf({1'b0, hi, nb, 1'b0, va[14:12]}), "R8 tile plo", tile_plo,
          memf({1'b0, hi, nb, 1'b0, va[14:12]}));
    check(tile_phi == memf({1'b0, hi, nb, 1'b1, va[14:12]}), "R8 tile phi", tile_phi,
          memf({1'b0, hi, nb, 1'b1, va[14:12]}));
  endtask

  task automatic idle_dot(input logic [8:0] d);
    @(negedge clk);
    dot = d;
    #1;
  endtask

  initial begin
    logic [7:0] held_name, held_phi;
    repeat (3) @(posedge clk);
    #1;
    check(tile_valid == 1'b0, "R1 valid in reset", tile_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    dot = 9'd1;
    #1;
    check(tile_valid == 1'b0, "R1 valid after reset", tile_valid, 0);
    check(rd_strobe == 1'b0, "R1 strobe render off", rd_strobe, 0);

    // Vector table walk
    render_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      run_group(V_SD[v], V_VA[v], V_HI[v], V_LN[v], V_NT[v], V_AT[v], 1'b1);
      idle_dot(9'd300);
      check_tile(V_NT[v], V_AT[v], V_HI[v], V_VA[v]);
    end
    idle_dot(9'd300);
    check(tile_valid == 1'b0, "R10 valid clears on take", tile_valid, 0);

    // R6: outside the window
    idle_dot(9'd0);   check(rd_strobe == 1'b0, "R6 dot 0", rd_strobe, 0);
    idle_dot(9'd257); check(rd_strobe == 1'b0, "R6 dot 257", rd_strobe, 0);
    idle_dot(9'd313); check(rd_strobe == 1'b0, "R6 dot 313", rd_strobe, 0);
    idle_dot(9'd337); check(rd_strobe == 1'b0, "R6 dot 337", rd_strobe, 0);
    run_group(9'd1, 15'h2345, 1'b0, 9'd240, 14'h2345, 14'h23F1, 1'b0);
    idle_dot(9'd300);
    check(tile_valid == 1'b0, "R6 no tile on line 240", tile_valid, 0);

    // R7: rendering disabled
    render_en = 1'b0;
    run_group(9'd33, 15'h5C87, 1'b1, 9'd10, 14'h2C87, 14'h2FC9, 1'b0);
    idle_dot(9'd300);
    check(tile_valid == 1'b0, "R7 no tile when off", tile_valid, 0);
    render_en = 1'b1;

    // R10: back-pressure
    tile_ready = 1'b0;
    run_group(9'd41, 15'h2345, 1'b0, 9'd20, 14'h2345, 14'h23F1, 1'b1);
    idle_dot(9'd300);
    check_tile(14'h2345, 14'h23F1, 1'b0, 15'h2345);
    held_name = tile_name; held_phi = tile_phi;
    run_group(9'd49, 15'h5C87, 1'b1, 9'd20, 14'h2C87, 14'h2FC9, 1'b1);
    idle_dot(9'd300);
    check(tile_valid == 1'b1, "R10 still valid", tile_valid, 1);
    check(tile_name == held_name, "R10 name held", tile_name, held_name);
    check(tile_phi == held_phi, "R10 phi held", tile_phi, held_phi);
    tile_ready = 1'b1;
    idle_dot(9'd300);
    check(tile_valid == 1'b0, "R10 valid clears", tile_valid, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule